// File: doc/BRIEF.md
# Charger Host Watchdog and Safety Timer

This block supervises a battery charger while charging is enabled. It does two jobs. First, it checks that the host is still managing the charger. Second, it puts a hard limit on how long charging may run without host control. It counts seconds on a tick that it derives internally from the clock.

While the host keeps writing over the serial bus, a host watchdog is restarted on each accepted write. If the host goes quiet for `WDOG_SECS` seconds, the block falls back to a safe mode. On that fall-back it asks the register block to restore default charge parameters. It also forces the input current limit to a low or high default, picked by a strap input, and starts a safety timer of `SAFE_SECS` seconds. The host cannot disable that timer. A new host write hands control back to the host.

The same safety timer also runs whenever the charger reports a shorted battery, and host writes do not stop it in that case. When the safety timer runs out, a timer fault is latched. The fault stays set until charging is switched off.

Top module: `chg_host_watchdog`

## Requirements
- R1: After reset every output is 0. While `chg_active` is 0, no timer advances and every output stays 0, however long that lasts.
- R2: Seconds are counted as one tick every `TICK_CYCLES` clocks. The k-th tick lands on the k-th multiple of `TICK_CYCLES` clock edges after the first edge at which `chg_active` is sampled 1. If `WDOG_SECS` ticks pass with no host write, `safe_mode` and `wdog_expired` rise on the edge of the last of those ticks.
- R3: A host write sampled on an edge restarts the watchdog; a tick on that same edge is not counted. Expiry then happens on the `WDOG_SECS`-th tick that falls strictly after the write.
- R4: `reload_req` is high for exactly one cycle, in the same cycle in which `safe_mode` rises, and at no other time.
- R5: While `safe_mode` is 1, `ilim_lo` equals `!lim_sel` and `ilim_hi` equals `lim_sel`. Outside safe mode both are 0.
- R6: A host write in safe mode, with no fault, clears `safe_mode` on the next edge and zeroes the safety count. `wdog_expired` stays 1 until charging stops.
- R7: After `SAFE_SECS` ticks counted in safe mode, `timer_fault` rises. It then holds, together with the current mode, while charging remains active, and host writes are ignored.
- R8: While `batt_short` is 1, the safety count advances on every tick, even in host mode. Host writes do not clear it, and `timer_fault` rises after `SAFE_SECS` such ticks.
- R9: When `chg_active` is sampled 0, `safe_mode`, `wdog_expired`, `timer_fault` and both limit outputs clear on that edge. A later start counts ticks from zero again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chg_active | input | 1 | Charging is enabled |
| host_wr | input | 1 | One-cycle strobe for an accepted host register write |
| batt_short | input | 1 | Battery voltage is in the short-circuit range |
| lim_sel | input | 1 | Default input limit strap: 0 low, 1 high |
| wdog_expired | output | 1 | Watchdog has expired since charging began |
| safe_mode | output | 1 | Fall-back (safe) mode is active |
| reload_req | output | 1 | One-cycle request to restore default charge parameters |
| timer_fault | output | 1 | Safety timer ran out; charging must stop |
| ilim_lo | output | 1 | Force the low default input current limit |
| ilim_hi | output | 1 | Force the high default input current limit |

## Verification
Suppose the watchdog count is wrong, or a write fails to clear it. Then `safe_mode` rises on the wrong tick edge, and this shows up on the very edge predicted from tick alignment. Suppose the safety count keeps stale seconds across a return to host mode. Then `timer_fault` appears one or more tick periods early, on a later entry into safe mode. If the fault latch or the mode hold is broken, a write after the fault changes `safe_mode` or `timer_fault` on the next edge.

// File: rtl/chg_wd_pkg.sv
package chg_wd_pkg;

    typedef enum logic {
        MODE_HOST = 1'b0,
        MODE_SAFE = 1'b1
    } wd_mode_e;

    typedef struct packed {
        logic expired;
        logic safe;
        logic reload;
        logic fault;
        logic lim_lo;
        logic lim_hi;
    } wd_flags_t;

    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sec_tick_gen.sv
module sec_tick_gen #(
    parameter int CYCLES = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic enable,
    output logic tick
);
    import chg_wd_pkg::*;

    localparam int CW = cnt_bits(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign tick = enable && !clear && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (enable) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sec_counter.sv
module sec_counter #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic done
);
    import chg_wd_pkg::*;

    localparam int CW = cnt_bits(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && !clear && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= done ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/chg_host_watchdog.sv
module chg_host_watchdog #(
    parameter int TICK_CYCLES = 100_000_000,
    parameter int WDOG_SECS   = 32,
    parameter int SAFE_SECS   = 900
) (
    input  logic clk,
    input  logic rst,
    input  logic chg_active,
    input  logic host_wr,
    input  logic batt_short,
    input  logic lim_sel,
    output logic wdog_expired,
    output logic safe_mode,
    output logic reload_req,
    output logic timer_fault,
    output logic ilim_lo,
    output logic ilim_hi
);
    import chg_wd_pkg::*;

    wd_mode_e  mode_q, mode_d;
    wd_flags_t flg_q, flg_d;

    logic tick;
    logic wd_clr, wd_run, wd_done;
    logic sf_clr, sf_run, sf_done;
    logic in_safe;

    assign in_safe = (mode_q == MODE_SAFE);

    sec_tick_gen #(.CYCLES(TICK_CYCLES)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .clear  (!chg_active),
        .enable (chg_active && !flg_q.fault),
        .tick   (tick)
    );

    // host watchdog: runs only in host mode; any write restarts it
    assign wd_run = chg_active && !flg_q.fault && !in_safe;
    assign wd_clr = !chg_active || host_wr || in_safe || flg_q.fault;

    sec_counter #(.LIMIT(WDOG_SECS)) u_wdog (
        .clk   (clk),
        .rst   (rst),
        .clear (wd_clr),
        .run   (wd_run),
        .tick  (tick),
        .done  (wd_done)
    );

    // safety timer: runs in safe mode or with a shorted battery
    assign sf_run = chg_active && !flg_q.fault && (in_safe || batt_short);
    assign sf_clr = !chg_active || (host_wr && !batt_short && !flg_q.fault);

    sec_counter #(.LIMIT(SAFE_SECS)) u_safe (
        .clk   (clk),
        .rst   (rst),
        .clear (sf_clr),
        .run   (sf_run),
        .tick  (tick),
        .done  (sf_done)
    );

    always_comb begin
        mode_d = mode_q;
        if (!chg_active) begin
            mode_d = MODE_HOST;
        end else if (!flg_q.fault) begin
            if (in_safe && host_wr) begin
                mode_d = MODE_HOST;
            end else if (wd_done) begin
                mode_d = MODE_SAFE;
            end
        end

        flg_d.expired = chg_active && (flg_q.expired || wd_done);
        flg_d.safe    = (mode_d == MODE_SAFE);
        flg_d.reload  = wd_done;
        flg_d.fault   = chg_active && (flg_q.fault || sf_done);
        flg_d.lim_lo  = (mode_d == MODE_SAFE) && !lim_sel;
        flg_d.lim_hi  = (mode_d == MODE_SAFE) && lim_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_HOST;
            flg_q  <= '0;
        end else begin
            mode_q <= mode_d;
            flg_q  <= flg_d;
        end
    end

    assign wdog_expired = flg_q.expired;
    assign safe_mode    = flg_q.safe;
    assign reload_req   = flg_q.reload;
    assign timer_fault  = flg_q.fault;
    assign ilim_lo      = flg_q.lim_lo;
    assign ilim_hi      = flg_q.lim_hi;
endmodule

// File: rtl/chg_host_watchdog_chk.sv
module chg_host_watchdog_chk (
    input logic clk,
    input logic rst,
    input logic chg_active,
    input logic host_wr,
    input logic batt_short,
    input logic lim_sel,
    input logic wdog_expired,
    input logic safe_mode,
    input logic reload_req,
    input logic timer_fault,
    input logic ilim_lo,
    input logic ilim_hi
);
    AST_RELOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reload_req |=> !reload_req); // R4

    AST_RELOAD_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(safe_mode) |-> reload_req); // R4

    AST_LIMIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ilim_lo, ilim_hi})); // R5

    AST_LIMIT_ONLY_SAFE: assert property (@(posedge clk) disable iff (rst)
        (ilim_lo || ilim_hi) |-> safe_mode); // R5

    AST_SAFE_HAS_EXPIRED: assert property (@(posedge clk) disable iff (rst)
        safe_mode |-> wdog_expired); // R2

    AST_WRITE_LEAVES_SAFE: assert property (@(posedge clk) disable iff (rst)
        (chg_active && safe_mode && host_wr && !timer_fault) |=> !safe_mode); // R6

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (chg_active && timer_fault) |=> timer_fault); // R7

    AST_FAULT_FREEZES_MODE: assert property (@(posedge clk) disable iff (rst)
        (chg_active && timer_fault) |=> $stable(safe_mode)); // R7

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !chg_active |=> (!safe_mode && !timer_fault && !wdog_expired)); // R9
endmodule

bind chg_host_watchdog chg_host_watchdog_chk u_chk (.*);

// File: tb/sim_chg_host_watchdog.sv
module sim_chg_host_watchdog;
    localparam int T = 4;
    localparam int W = 8;
    localparam int S = 20;

    localparam int SIG_EXP = 0, SIG_SAFE = 1, SIG_RELOAD = 2, SIG_FAULT = 3,
                   SIG_LO = 4, SIG_HI = 5;

    typedef struct {
        int    at;
        int    sig;
        logic  val;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chg_active = 1'b0;
    logic host_wr = 1'b0;
    logic batt_short = 1'b0;
    logic lim_sel = 1'b0;
    logic wdog_expired, safe_mode, reload_req, timer_fault, ilim_lo, ilim_hi;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    chg_host_watchdog #(.TICK_CYCLES(T), .WDOG_SECS(W), .SAFE_SECS(S)) u0 (
        .clk(clk), .rst(rst), .chg_active(chg_active), .host_wr(host_wr),
        .batt_short(batt_short), .lim_sel(lim_sel),
        .wdog_expired(wdog_expired), .safe_mode(safe_mode),
        .reload_req(reload_req), .timer_fault(timer_fault),
        .ilim_lo(ilim_lo), .ilim_hi(ilim_hi)
    );

    // monitor: pops expectations due at this cycle
    always @(negedge clk) begin
        logic [5:0] obs;
        exp_t it;
        obs = {ilim_hi, ilim_lo, timer_fault, reload_req, safe_mode, wdog_expired};
        while (q.size() > 0 && q[0].at <= cyc) begin
            it = q.pop_front();
            checks++;
            if (it.at != cyc) begin
                failures++;
                $display("FAIL %s sig%0d missed cycle actual=%0d expected=%0d",
                         it.req, it.sig, cyc, it.at);
            end else if (obs[it.sig] !== it.val) begin
                failures++;
                $display("FAIL %s sig%0d at cycle %0d actual=%b expected=%b",
                         it.req, it.sig, cyc, obs[it.sig], it.val);
            end
        end
    end

    task automatic want(input int at, input int sig, input logic v, input string rq);
        exp_t it;
        it.at = at; it.sig = sig; it.val = v; it.req = rq;
        q.push_back(it);
    endtask

    task automatic wait_to(input int x);
        while (cyc < x) @(negedge clk);
    endtask

    task automatic pulse_wr();
        host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    function automatic int next_tick(input int c0, input int e);
        return c0 + T * ((e - c0) / T + 1);
    endfunction

    initial begin
        int c0, e, e2, xa, xb, f, g, e2s, fs;
        @(negedge clk);
        wait_to(3);
        rst = 1'b0;
        // R1: reset state
        for (int s = 0; s < 6; s++) want(cyc + 1, s, 1'b0, "R1");
        // R1: idle charger never advances
        want(cyc + 3*W*T, SIG_SAFE, 1'b0, "R1");
        want(cyc + 3*W*T, SIG_EXP, 1'b0, "R1");
        want(cyc + 3*W*T, SIG_FAULT, 1'b0, "R1");
        wait_to(cyc + 3*W*T + 1);

        // R2, R4, R5: expiry with no writes, low default limit
        c0 = cyc;
        e = c0 + W*T;
        want(e - 1, SIG_SAFE, 1'b0, "R2");
        want(e - 1, SIG_EXP, 1'b0, "R2");
        want(e, SIG_SAFE, 1'b1, "R2");
        want(e, SIG_EXP, 1'b1, "R2");
        want(e, SIG_RELOAD, 1'b1, "R4");
        want(e, SIG_LO, 1'b1, "R5");
        want(e, SIG_HI, 1'b0, "R5");
        want(e + 1, SIG_RELOAD, 1'b0, "R4");
        want(e + 1, SIG_SAFE, 1'b1, "R2");
        lim_sel = 1'b0;
        chg_active = 1'b1;
        wait_to(e + T + 1);

        // R6: write in safe mode returns to host mode
        e = cyc + 1;
        want(e, SIG_SAFE, 1'b0, "R6");
        want(e, SIG_LO, 1'b0, "R5");
        want(e, SIG_EXP, 1'b1, "R6");
        pulse_wr();
        // R3: a second write restarts the watchdog again
        xa = next_tick(c0, e) + (W-1)*T;
        wait_to(e + 2*T);
        e2 = cyc + 1;
        xb = next_tick(c0, e2) + (W-1)*T;
        want(xa, SIG_SAFE, 1'b0, "R3");
        want(xb - 1, SIG_SAFE, 1'b0, "R3");
        want(xb, SIG_SAFE, 1'b1, "R3");
        want(xb, SIG_RELOAD, 1'b1, "R4");
        pulse_wr();
        wait_to(xb + 1);

        // R7: safety timeout in safe mode (count was zeroed by the R6 write)
        f = xb + S*T;
        want(f - 1, SIG_FAULT, 1'b0, "R7");
        want(f, SIG_FAULT, 1'b1, "R7");
        wait_to(f + 1);
        want(f + 3, SIG_FAULT, 1'b1, "R7");
        want(f + 3, SIG_SAFE, 1'b1, "R7");
        pulse_wr();
        want(f + 3*T, SIG_FAULT, 1'b1, "R7");
        wait_to(f + 3*T + 1);

        // R9: stopping charge clears everything
        g = cyc;
        want(g + 1, SIG_FAULT, 1'b0, "R9");
        want(g + 1, SIG_SAFE, 1'b0, "R9");
        want(g + 1, SIG_EXP, 1'b0, "R9");
        want(g + 1, SIG_LO, 1'b0, "R9");
        chg_active = 1'b0;
        lim_sel = 1'b1;
        wait_to(g + 5);
        // R9 restart from zero, R5 high default
        c0 = cyc;
        e = c0 + W*T;
        want(e - 1, SIG_SAFE, 1'b0, "R9");
        want(e, SIG_SAFE, 1'b1, "R9");
        want(e, SIG_HI, 1'b1, "R5");
        want(e, SIG_LO, 1'b0, "R5");
        chg_active = 1'b1;
        wait_to(e + 2);

        // R8: shorted battery bounds charge time despite host writes
        g = cyc;
        chg_active = 1'b0;
        wait_to(g + 3);
        c0 = cyc;
        e2s = c0 + 1;
        fs = c0 + T * ((e2s - c0 + T - 1) / T) + (S-1)*T;
        want(fs - 1, SIG_FAULT, 1'b0, "R8");
        want(fs, SIG_FAULT, 1'b1, "R8");
        want(fs, SIG_SAFE, 1'b0, "R8");
        chg_active = 1'b1;
        batt_short = 1'b1;
        while (cyc < fs + 2) begin
            pulse_wr();
            wait_to(cyc + 3*T - 1);
        end
        batt_short = 1'b0;
        wait_to(cyc + 3);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule